// File: doc/BRIEF.md
# Link Width Training Controller

This block sequences the bring-up of a serial link built from two four-lane ports that may be fused into one eight-lane port. It works on abstract events: the physical layer reports which ports saw a partner answer, the link ID returned on each port, a pass or fail verdict for each width attempt, single error events on a running link, and the outcome of a recovery pass. The controller decides the port arrangement and the width to attempt. It steps the width down after each failed attempt and reports when the link is up.

On a running link, a burst of errors sends the controller into recovery. Recovery keeps the negotiated width and arrangement, and software gets a one-cycle notification when it starts. A recovery that fails sends the controller back to polling. From there a full training pass runs again, and a one-cycle reset pulse goes toward the downstream device. If even a one-lane attempt fails, the controller waits a programmable number of idle cycles and then polls again.

Top module: `lane_width_trainer`

## Requirements
- R1: While reset is held and right after it is released, `phase_o` reads polling (code 0), and `link_up_o`, `sw_note_o` and `dn_reset_o` are all low.
- R2: In polling, when `partner_seen_i` is 2'b11 and both reported IDs are equal, the next cycle shows training (phase code 1), `merged_o` high and width code 3. Width codes are: 3 = eight lanes, 2 = four, 1 = two, 0 = one.
- R3: In polling, when any other nonzero `partner_seen_i` pattern is seen, or the two IDs differ, the next cycle shows training with `merged_o` low and width code 2. With `partner_seen_i` zero, polling holds.
- R4: A failed attempt at a width wider than one lane stays in training and lowers the width code by exactly one in the next cycle.
- R5: A passed attempt at any width, one lane included, gives active (phase code 2) and `link_up_o` high in the next cycle, with the width unchanged.
- R6: A failed one-lane attempt gives idle (phase code 4) for exactly IDLE_CYC cycles, then polling. The next training pass starts again from the widest width the ports allow.
- R7: `link_up_o` is high exactly when the phase is active.
- R8: On an active link, the ERR_TH-th error pulse moves the phase to recovery (code 3) in the next cycle. In that same cycle `sw_note_o` is high for exactly one cycle.
- R9: Width and `merged_o` do not change while in recovery.
- R10: A successful recovery returns the phase to active and clears the error count, so that ERR_TH further error pulses are needed to re-enter recovery. This holds even if an error pulse arrives in the same cycle as the result.
- R11: A failed recovery gives polling in the next cycle, with `dn_reset_o` high for that single cycle only.
- R12: `dn_reset_o` stays low on the first bring-up after reset and on the return to polling from idle.
- R13: Error pulses outside the active phase, during training or recovery, do not count toward ERR_TH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| partner_seen_i | input | 2 | Partner answered on port A (bit 0) / port B (bit 1) |
| partner_id_a_i | input | ID_W | Link ID reported through port A |
| partner_id_b_i | input | ID_W | Link ID reported through port B |
| train_done_i | input | 1 | Result of the current width attempt is valid |
| train_pass_i | input | 1 | Width attempt passed (with train_done_i) |
| err_i | input | 1 | One link error event |
| recov_done_i | input | 1 | Recovery outcome is valid |
| recov_pass_i | input | 1 | Recovery succeeded (with recov_done_i) |
| phase_o | output | 3 | 0 polling, 1 training, 2 active, 3 recovery, 4 idle |
| merged_o | output | 1 | Both ports fused into one eight-lane port |
| width_o | output | 2 | Width attempted or in use (code per R2) |
| link_up_o | output | 1 | Link operational |
| sw_note_o | output | 1 | One-cycle software notification on recovery entry |
| dn_reset_o | output | 1 | One-cycle downstream reset on retrain |

## Verification
Two events can land in one cycle: a recovery result, which clears the error count, and an error pulse, which would otherwise add to it. The bench raises `err_i` in the same cycle as a successful `recov_done_i`. It then sends ERR_TH-1 further errors and expects the link to stay active, and expects the next error to trigger recovery. Random error pulses are also driven during width attempts, and the bench confirms that they do not shorten the burst needed on the active link.

// File: rtl/lwt_pkg.sv
package lwt_pkg;
  typedef enum logic [2:0] {
    PH_POLL   = 3'd0,
    PH_TRAIN  = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_RECOV  = 3'd3,
    PH_IDLE   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    W_X1 = 2'd0,
    W_X2 = 2'd1,
    W_X4 = 2'd2,
    W_X8 = 2'd3
  } width_e;
endpackage

// File: rtl/lwt_merge_decide.sv
module lwt_merge_decide
  import lwt_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [1:0]      seen,
  input  logic [ID_W-1:0] id_a,
  input  logic [ID_W-1:0] id_b,
  output logic            fuse,
  output width_e          top_w
);
  always_comb begin
    fuse  = (&seen) && (id_a == id_b);
    top_w = fuse ? W_X8 : W_X4;
  end
endmodule

// File: rtl/lwt_err_count.sv
module lwt_err_count #(
  parameter int ERR_TH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic err,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(ERR_TH + 1);
  localparam logic [CW-1:0] LAST = CW'(ERR_TH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (en && err);
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
    hit    = en && err && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lwt_idle_timer.sv
module lwt_idle_timer #(
  parameter int IDLE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int TW = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(IDLE_CYC - 1);

  logic [TW-1:0] t_q, t_d;

  always_comb begin
    t_d  = run ? t_q + TW'(1) : '0;
    done = run && (t_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_d;
  end
endmodule

// File: rtl/lane_width_trainer.sv
module lane_width_trainer
  import lwt_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int ERR_TH   = 4,
  parameter int IDLE_CYC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      partner_seen_i,
  input  logic [ID_W-1:0] partner_id_a_i,
  input  logic [ID_W-1:0] partner_id_b_i,
  input  logic            train_done_i,
  input  logic            train_pass_i,
  input  logic            err_i,
  input  logic            recov_done_i,
  input  logic            recov_pass_i,
  output logic [2:0]      phase_o,
  output logic            merged_o,
  output logic [1:0]      width_o,
  output logic            link_up_o,
  output logic            sw_note_o,
  output logic            dn_reset_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  phase_e state_q, state_d;
  width_e width_q, width_d;
  logic   merged_q, merged_d, cfg_en;
  logic   up_q, note_q, note_d, dnrst_q, dnrst_d;
  logic   fuse;
  width_e top_w;
  logic   err_hit, cnt_clr, idle_done;

  lwt_merge_decide #(.ID_W(ID_W)) u_merge (
    .seen  (partner_seen_i),
    .id_a  (partner_id_a_i),
    .id_b  (partner_id_b_i),
    .fuse  (fuse),
    .top_w (top_w)
  );

  lwt_err_count #(.ERR_TH(ERR_TH)) u_errs (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (state_q == PH_ACTIVE),
    .err   (err_i),
    .clr   (cnt_clr),
    .hit   (err_hit)
  );

  lwt_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (state_q == PH_IDLE),
    .done  (idle_done)
  );

  always_comb begin
    state_d  = state_q;
    width_d  = width_q;
    merged_d = merged_q;
    note_d   = 1'b0;
    dnrst_d  = 1'b0;
    cnt_clr  = 1'b0;
    unique case (state_q)
      PH_POLL: begin
        cnt_clr = 1'b1;
        if (|partner_seen_i) begin
          state_d  = PH_TRAIN;
          merged_d = fuse;
          width_d  = top_w;
        end
      end
      PH_TRAIN: begin
        if (train_done_i) begin
          if (train_pass_i)         state_d = PH_ACTIVE;
          else if (width_q == W_X1) state_d = PH_IDLE;
          else                      width_d = width_e'(width_q - 2'd1);
        end
      end
      PH_IDLE: begin
        if (idle_done) state_d = PH_POLL;
      end
      PH_ACTIVE: begin
        if (err_hit) begin
          state_d = PH_RECOV;
          note_d  = 1'b1;
        end
      end
      PH_RECOV: begin
        if (recov_done_i) begin
          if (recov_pass_i) begin
            state_d = PH_ACTIVE;
            cnt_clr = 1'b1;
          end else begin
            state_d = PH_POLL;
            dnrst_d = 1'b1;
          end
        end
      end
      default: state_d = PH_POLL;
    endcase
    cfg_en = (state_q == PH_POLL) || (state_q == PH_TRAIN);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= PH_POLL;
      up_q    <= 1'b0;
      note_q  <= 1'b0;
      dnrst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      up_q    <= (state_d == PH_ACTIVE);
      note_q  <= note_d;
      dnrst_q <= dnrst_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      width_q  <= W_X1;
      merged_q <= 1'b0;
    end else if (cfg_en) begin
      width_q  <= width_d;
      merged_q <= merged_d;
    end
  end

  assign phase_o    = state_q;
  assign merged_o   = merged_q;
  assign width_o    = width_q;
  assign link_up_o  = up_q;
  assign sw_note_o  = note_q;
  assign dn_reset_o = dnrst_q;
endmodule

// File: rtl/lane_width_trainer_chk.sv
module lane_width_trainer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase_o,
  input logic       merged_o,
  input logic [1:0] width_o,
  input logic       link_up_o,
  input logic       sw_note_o,
  input logic       dn_reset_o
);
  a_r7_up_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    link_up_o == (phase_o == 3'd2));

  a_r8_note_single: assert property (@(posedge clk) disable iff (!rst_n)
    sw_note_o |=> !sw_note_o);

  a_r8_note_on_recov: assert property (@(posedge clk) disable iff (!rst_n)
    sw_note_o |-> (phase_o == 3'd3) && ($past(phase_o) == 3'd2));

  a_r11_dnrst_single: assert property (@(posedge clk) disable iff (!rst_n)
    dn_reset_o |=> !dn_reset_o);

  a_r11_dnrst_from_recov: assert property (@(posedge clk) disable iff (!rst_n)
    dn_reset_o |-> (phase_o == 3'd0) && ($past(phase_o) == 3'd3));

  a_r9_recov_holds_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd3) |-> $stable(width_o) && $stable(merged_o));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 3'd1) && ($past(phase_o) == 3'd1) && (width_o != $past(width_o)))
      |-> (width_o == $past(width_o) - 2'd1));

  a_r2_fused_starts_wide: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 3'd1) && ($past(phase_o) == 3'd0) && merged_o) |-> (width_o == 2'd3));
endmodule

bind lane_width_trainer lane_width_trainer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_o    (phase_o),
  .merged_o   (merged_o),
  .width_o    (width_o),
  .link_up_o  (link_up_o),
  .sw_note_o  (sw_note_o),
  .dn_reset_o (dn_reset_o)
);

// File: tb/lane_width_trainer_test.sv
module lane_width_trainer_test;
  localparam int CLK_PER  = 10;
  localparam int ID_W     = 8;
  localparam int ERR_TH   = 4;
  localparam int IDLE_CYC = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      seen;
  logic [ID_W-1:0] id_a, id_b;
  logic            t_done, t_pass, err, r_done, r_pass;
  logic [2:0]      phase;
  logic            merged, up, note, dnrst;
  logic [1:0]      width;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  lane_width_trainer #(.ID_W(ID_W), .ERR_TH(ERR_TH), .IDLE_CYC(IDLE_CYC)) uut (
    .clk(clk), .rst_n(rst_n),
    .partner_seen_i(seen), .partner_id_a_i(id_a), .partner_id_b_i(id_b),
    .train_done_i(t_done), .train_pass_i(t_pass), .err_i(err),
    .recov_done_i(r_done), .recov_pass_i(r_pass),
    .phase_o(phase), .merged_o(merged), .width_o(width),
    .link_up_o(up), .sw_note_o(note), .dn_reset_o(dnrst)
  );

  function automatic logic exp_fuse(logic [1:0] s, logic [ID_W-1:0] a, logic [ID_W-1:0] b);
    return (s == 2'b11) && (a == b);
  endfunction

  function automatic logic [1:0] exp_top(logic f);
    return f ? 2'd3 : 2'd2;
  endfunction

  task automatic chk(string req, int act, int exp_v, string what);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bring_up(logic [1:0] s, logic [ID_W-1:0] a, logic [ID_W-1:0] b,
                          output logic f);
    f = exp_fuse(s, a, b);
    seen = s; id_a = a; id_b = b;
    tick();
    seen = 2'b00;
    chk(f ? "R2" : "R3", phase, 1, "phase after partner seen");
    chk(f ? "R2" : "R3", merged, f, "port fusion");
    chk(f ? "R2" : "R3", width, exp_top(f), "first width");
    chk("R12", dnrst, 0, "no downstream reset on bring-up");
  endtask

  task automatic attempt(logic pass, logic noise);
    t_done = 1'b1; t_pass = pass; err = noise;
    tick();
    t_done = 1'b0; err = 1'b0;
  endtask

  task automatic errs_keep_active(int n);
    for (int i = 0; i < n; i++) begin
      err = 1'b1;
      tick();
      err = 1'b0;
      chk("R13", phase, 2, "stays active below threshold");
      chk("R7", up, 1, "link up while active");
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) tick();
    end
  endtask

  task automatic last_err(int w, logic f);
    err = 1'b1;
    tick();
    err = 1'b0;
    chk("R8", phase, 3, "recovery after burst");
    chk("R8", note, 1, "notification pulse");
    chk("R7", up, 0, "link down in recovery");
    chk("R9", width, w, "width kept in recovery");
    chk("R9", merged, f, "fusion kept in recovery");
    err = 1'b1;
    tick();
    err = 1'b0;
    chk("R8", note, 0, "notification single cycle");
    chk("R13", phase, 3, "errors in recovery ignored");
  endtask

  task automatic fail_recovery();
    r_done = 1'b1; r_pass = 1'b0;
    tick();
    r_done = 1'b0;
    chk("R11", phase, 0, "polling after failed recovery");
    chk("R11", dnrst, 1, "downstream reset");
    tick();
    chk("R11", dnrst, 0, "downstream reset single cycle");
    chk("R3", phase, 0, "polling holds without partner");
  endtask

  initial begin
    logic f;
    int   w;
    void'($urandom(32'd4242));
    rst_n = 1'b0; seen = '0; id_a = '0; id_b = '0;
    t_done = 0; t_pass = 0; err = 0; r_done = 0; r_pass = 0;
    repeat (3) tick();
    chk("R1", phase, 0, "phase in reset");
    chk("R1", up, 0, "link up in reset");
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", phase, 0, "phase after reset");
    chk("R1", note, 0, "note after reset");
    chk("R1", dnrst, 0, "downstream reset after reset");
    chk("R7", up, 0, "link down after reset");

    // directed: single port, every width fails, idle wait, restart
    bring_up(2'b10, 8'h11, 8'h11, f);
    for (int k = 2; k >= 1; k--) begin
      attempt(1'b0, 1'b1);
      chk("R4", width, k - 1, "step down");
      chk("R4", phase, 1, "still training");
    end
    attempt(1'b0, 1'b0);
    for (int i = 0; i < IDLE_CYC; i++) begin
      chk("R6", phase, 4, "idle after one-lane fail");
      chk("R12", dnrst, 0, "no reset during idle");
      tick();
    end
    chk("R6", phase, 0, "polling after idle");
    chk("R12", dnrst, 0, "no reset after idle");
    bring_up(2'b11, 8'h5A, 8'h5A, f);
    chk("R6", width, 3, "restart from widest");
    for (int k = 0; k < 3; k++) attempt(1'b0, 1'b0);
    attempt(1'b1, 1'b0);
    chk("R5", phase, 2, "active at one lane");
    chk("R5", up, 1, "link up at one lane");
    chk("R5", width, 0, "one-lane width");
    errs_keep_active(ERR_TH - 1);
    last_err(0, 1'b1);
    fail_recovery();

    // random bring-ups
    for (int it = 0; it < 24; it++) begin
      logic [1:0]      s;
      logic [ID_W-1:0] a, b;
      int              nf;
      s = 2'($urandom_range(1, 3));
      a = ID_W'($urandom());
      b = ($urandom_range(0, 1) == 1) ? a : ID_W'($urandom());
      bring_up(s, a, b, f);
      w  = exp_top(f);
      nf = $urandom_range(0, w);
      for (int k = 0; k < nf; k++) begin
        attempt(1'b0, 1'($urandom_range(0, 1)));
        w = w - 1;
        chk("R4", width, w, "random step down");
      end
      attempt(1'b1, 1'($urandom_range(0, 1)));
      chk("R5", phase, 2, "active after pass");
      chk("R5", width, w, "width after pass");
      errs_keep_active(ERR_TH - 1);
      last_err(w, f);
      if ($urandom_range(0, 1) == 1) begin
        r_done = 1'b1; r_pass = 1'b1; err = 1'b1;
        tick();
        r_done = 1'b0; err = 1'b0;
        chk("R10", phase, 2, "active after recovery");
        chk("R10", width, w, "width after recovery");
        errs_keep_active(ERR_TH - 1);
        last_err(w, f);
      end
      fail_recovery();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule